// File: doc/BRIEF.md
# Ramped Tuning-Word Generator with Phase Accumulator

This block produces a 48-bit frequency tuning word and integrates it into a 48-bit phase value on every clock. The tuning word is either a fixed value or a base value plus a linearly growing offset. The offset comes from a frequency accumulator. It adds a signed step once per ramp tick, and a programmable 20-bit down-counter divides the system clock to produce that tick.

Three operating styles are available. In fixed-tone mode the first base word drives the phase accumulator directly. In sweep mode the offset ramps on top of the base that the select input chooses. In stepped-shift mode the offset also ramps, and any change of the select input restarts it from zero, so the output moves smoothly toward the newly chosen base. Four write strobes share one data bus and load the two base words, the step and the tick divisor.

Top module: `freq_sweep_dds`

## Requirements
- R1: While reset is asserted, and on the first sample after it, `ftw_o` and `phase_o` are zero, and all stored words, the divider count and the offset are zero.
- R2: When `mode_i` is 2'b00 or 2'b11 (fixed tone), `ftw_o` equals the first base word, whatever `tone_sel_i`, the step word or the divisor hold.
- R3: At every clock edge `phase_o` becomes its previous value plus the previous `ftw_o`, modulo 2^48.
- R4: The divider count reloads the stored divisor on the edge after it reads zero and otherwise decrements, so a divisor N gives one ramp tick every N+1 clocks and a divisor of 0 gives a tick every clock.
- R5: In sweep mode (`mode_i` 2'b10) the offset gains the step word at each ramp tick and holds otherwise, and `ftw_o` is the selected base plus the offset.
- R6: In the two ramping modes, `tone_sel_i` = 0 selects the first base word and `tone_sel_i` = 1 selects the second.
- R7: In stepped-shift mode (`mode_i` 2'b01), an edge at which `tone_sel_i` differs from its value at the previous edge sets the offset to zero, and this takes priority over a ramp tick.
- R8: The step word is two's complement, and the offset and the tuning word wrap modulo 2^48, so downward ramps are produced.
- R9: `acc_clr_i` zeroes the offset at the next edge and leaves the base words, the step and the divisor unchanged.
- R10: A write strobe stores `wr_data_i` (the divisor takes its low 20 bits) at the edge, and the new value is in use from the next cycle on. A new divisor is first used at the next reload.
- R11: In fixed-tone mode the offset is held at zero, so a ramp started afterwards begins from the base word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00/11 fixed tone, 01 stepped shift, 10 sweep |
| tone_sel_i | input | 1 | Base word select: 0 first, 1 second |
| ftw1_wr_i | input | 1 | Write strobe for the first base word |
| ftw2_wr_i | input | 1 | Write strobe for the second base word |
| step_wr_i | input | 1 | Write strobe for the signed step word |
| div_wr_i | input | 1 | Write strobe for the tick divisor |
| wr_data_i | input | 48 | Shared write data |
| acc_clr_i | input | 1 | Synchronous clear of the offset |
| ftw_o | output | 48 | Current tuning word |
| phase_o | output | 48 | Phase accumulator value |

## Verification
The assertions assume that the inputs are stable around each rising edge and that reset is released in step with the clock, so every past value they use comes from a defined register. All four `mode_i` codes are legal, so the checks do not restrict the mode. The stimulus changes inputs one time unit after each edge and keeps the divisor small in its random phase, so ticks, select toggles and clears often fall on the same edge. Every write carries a full 48-bit random value, so the wrap of the offset and of the phase is exercised.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [1:0] {
    MODE_TONE     = 2'b00,
    MODE_SHIFT    = 2'b01,
    MODE_SWEEP    = 2'b10,
    MODE_TONE_ALT = 2'b11
  } sweep_mode_e;
endpackage

// File: rtl/ramp_tick_div.sv
module ramp_tick_div #(
  parameter int RATE_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

  logic [RATE_W-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == '0);

  always_comb begin
    if (tick_o) cnt_d = rate_i;
    else        cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: after a tick the count holds the divisor; otherwise it decrements
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> cnt_q == $past(rate_i));
  p_countdown_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> cnt_q == $past(cnt_q) - ONE);
endmodule

// File: rtl/delta_accum.sv
module delta_accum #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] acc_o
);
  logic [W-1:0] acc_q, acc_d;
  logic         acc_en;

  assign acc_en = clr_i | (run_i & tick_i);

  always_comb begin
    acc_d = acc_q;
    if (clr_i)       acc_d = '0;
    else if (acc_en) acc_d = acc_q + step_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> acc_o == '0);
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && !clr_i) |=> acc_o == $past(acc_o) + $past(step_i));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(acc_o));
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ftw_i,
  output logic [W-1:0] phase_o
);
  logic [W-1:0] ph_q, ph_d;

  always_comb ph_d = ph_q + ftw_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  assign phase_o = ph_q;

  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase_o == $past(phase_o) + $past(ftw_i));
endmodule

// File: rtl/freq_sweep_dds.sv
module freq_sweep_dds #(
  parameter int FTW_W  = 48,
  parameter int RATE_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             tone_sel_i,
  input  logic             ftw1_wr_i,
  input  logic             ftw2_wr_i,
  input  logic             step_wr_i,
  input  logic             div_wr_i,
  input  logic [FTW_W-1:0] wr_data_i,
  input  logic             acc_clr_i,
  output logic [FTW_W-1:0] ftw_o,
  output logic [FTW_W-1:0] phase_o
);
  import sweep_pkg::*;

  localparam int NREG = 3;

  sweep_mode_e mode;
  logic [FTW_W-1:0]  word_q [NREG];
  logic [FTW_W-1:0]  word_d [NREG];
  logic [NREG-1:0]   word_we;
  logic [RATE_W-1:0] div_q, div_d;
  logic              sel_q;
  logic              ramp_on, shift_swap, acc_clear, tick;
  logic [FTW_W-1:0]  acc, base;

  assign mode    = sweep_mode_e'(mode_i);
  assign word_we = {step_wr_i, ftw2_wr_i, ftw1_wr_i};

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_word
      always_comb word_d[g] = word_we[g] ? wr_data_i : word_q[g];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          word_q[g] <= '0;
        else if (word_we[g]) word_q[g] <= word_d[g];
      end
    end
  endgenerate

  always_comb div_d = div_wr_i ? wr_data_i[RATE_W-1:0] : div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (div_wr_i) div_q <= div_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= tone_sel_i;
  end

  always_comb begin
    ramp_on    = (mode == MODE_SHIFT) || (mode == MODE_SWEEP);
    shift_swap = (mode == MODE_SHIFT) && (tone_sel_i != sel_q);
    acc_clear  = acc_clr_i || !ramp_on || shift_swap;
    base       = tone_sel_i ? word_q[1] : word_q[0];
    ftw_o      = ramp_on ? (base + acc) : word_q[0];
  end

  ramp_tick_div #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .rate_i(div_q), .tick_o(tick)
  );

  delta_accum #(.W(FTW_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run_i(ramp_on), .tick_i(tick),
    .clr_i(acc_clear), .step_i(word_q[2]), .acc_o(acc)
  );

  phase_accum #(.W(FTW_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .ftw_i(ftw_o), .phase_o(phase_o)
  );

  // R7: a select change in stepped-shift mode restarts the offset
  p_shift_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01 && tone_sel_i != sel_q) |=> acc == '0);
  // R11: fixed-tone mode keeps the offset at zero
  p_tone_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 || mode_i == 2'b11) |=> acc == '0);
  // R9: a clear leaves the stored words unchanged
  p_clr_keeps_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clr_i && !ftw1_wr_i && !ftw2_wr_i) |=> $stable(word_q[0]) && $stable(word_q[1]));
endmodule

// File: tb/test_freq_sweep_dds.sv
module test_freq_sweep_dds;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sel = 1'b0, w1 = 1'b0, w2 = 1'b0, wd = 1'b0, wr = 1'b0, clr = 1'b0;
  logic [47:0] wdata = '0;
  logic [47:0] ftw_o, phase_o;

  int n_tests = 0, n_fail = 0;
  logic [47:0] m_f1, m_f2, m_dl, m_acc, m_ph;
  logic [19:0] m_rate, m_cnt;
  logic        m_sel;

  always #2.5 clk = ~clk;

  freq_sweep_dds i_freq_sweep_dds (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .tone_sel_i(sel),
    .ftw1_wr_i(w1), .ftw2_wr_i(w2), .step_wr_i(wd), .div_wr_i(wr),
    .wr_data_i(wdata), .acc_clr_i(clr), .ftw_o(ftw_o), .phase_o(phase_o)
  );

  function automatic logic [47:0] exp_ftw();
    if (mode == 2'b01 || mode == 2'b10) return (sel ? m_f2 : m_f1) + m_acc;
    return m_f1;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_f1 = '0; m_f2 = '0; m_dl = '0; m_acc = '0; m_ph = '0;
    m_rate = '0; m_cnt = '0; m_sel = 1'b0;
  endtask

  // one clock: advance the model with the inputs seen at the edge, then compare
  task automatic step(input string tag);
    logic [47:0] f_old;
    logic        ramp, tk;
    @(posedge clk);
    #1;
    f_old = exp_ftw();
    ramp  = (mode == 2'b01 || mode == 2'b10);
    tk    = (m_cnt == '0);
    m_ph  = m_ph + f_old;
    if (clr || !ramp || (mode == 2'b01 && sel != m_sel)) m_acc = '0;
    else if (tk) m_acc = m_acc + m_dl;
    m_cnt = tk ? m_rate : m_cnt - 20'd1;
    if (w1) m_f1 = wdata;
    if (w2) m_f2 = wdata;
    if (wd) m_dl = wdata;
    if (wr) m_rate = wdata[19:0];
    m_sel = sel;
    check(ftw_o === exp_ftw(), {tag, " ftw"}, ftw_o, exp_ftw());
    check(phase_o === m_ph, {tag, " phase"}, phase_o, m_ph);
  endtask

  task automatic write(input int which, input logic [47:0] d);
    wdata = d;
    w1 = (which == 0); w2 = (which == 1); wd = (which == 2); wr = (which == 3);
    step("R10 write");
    w1 = 0; w2 = 0; wd = 0; wr = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [47:0] prev;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check(ftw_o === '0, "R1 reset ftw", ftw_o, '0);
    check(phase_o === '0, "R1 reset phase", phase_o, '0);
    rst_n = 1'b1;
    step("R1 first");

    write(0, 48'd1000);
    write(1, 48'd5000);
    write(2, 48'd7);
    write(3, 48'd2);

    mode = 2'b00; sel = 1'b1;
    for (int i = 0; i < 6; i++) step("R2 tone");
    check(ftw_o === 48'd1000, "R2 tone base", ftw_o, 48'd1000);
    mode = 2'b11;
    step("R2 tone alt");
    check(ftw_o === 48'd1000, "R2 tone alt base", ftw_o, 48'd1000);

    mode = 2'b10; sel = 1'b0;
    for (int i = 0; i < 12; i++) step("R5 sweep");
    sel = 1'b1;
    for (int i = 0; i < 8; i++) step("R6 sweep f2");

    write(3, 48'd0);
    for (int i = 0; i < 3; i++) step("R4 settle");
    prev = ftw_o;
    step("R4 rate0");
    check(ftw_o - prev === 48'd7, "R4 tick each clock", ftw_o - prev, 48'd7);

    mode = 2'b01;
    for (int i = 0; i < 5; i++) step("R7 shift");
    sel = 1'b0;
    step("R7 swap");
    check(ftw_o === 48'd1000, "R7 restart at base", ftw_o, 48'd1000);
    for (int i = 0; i < 5; i++) step("R7 ramp");

    write(2, -48'sd3);
    mode = 2'b10;
    prev = ftw_o;
    step("R8 down");
    check(ftw_o === prev - 48'd3, "R8 downward", ftw_o, prev - 48'd3);
    write(0, 48'd2);
    for (int i = 0; i < 4; i++) step("R8 wrap");

    clr = 1'b1;
    step("R9 clear");
    clr = 1'b0;
    check(ftw_o === 48'd2, "R9 offset zero", ftw_o, 48'd2);
    mode = 2'b00;
    step("R9 regs kept");
    check(ftw_o === 48'd2, "R9 f1 kept", ftw_o, 48'd2);
    mode = 2'b10; sel = 1'b1;
    step("R11 restart");
    check(ftw_o === 48'd5000 - 48'd3, "R11 ramp from base", ftw_o, 48'd4997);

    mode = 2'b00;
    write(0, 48'hFFFF_FFFF_FFFB);
    for (int i = 0; i < 6; i++) step("R3 phase wrap");

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 31);
      if (r == 0) mode = 2'($urandom_range(0, 3));
      if (r == 1) sel = ~sel;
      clr = (r == 2);
      wdata = {$urandom, $urandom};
      w1 = (r == 3); w2 = (r == 4); wd = (r == 5);
      wr = (r == 6);
      if (wr) wdata[19:0] = 20'($urandom_range(0, 5));
      step("RND mixed");
      w1 = 0; w2 = 0; wd = 0; wr = 0; clr = 0;
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule